// File: doc/BRIEF.md
# Instruction Sequencing Controller

This block is the control core of a single-issue processor that does not pipeline. It moves one instruction at a time through fetch, the wait for the instruction reply, execution, the wait for data translation and the data memory access. It talks to the instruction port and the data port through a request/grant/response handshake. A request that the port does not grant is held in a dedicated retry state until the port takes it. The datapath, decoder and address translation sit outside the block. They report to it through single-bit strobes: whether the instruction touches memory, whether it is a prefetch, whether execution faulted, and translation done or faulted.

The block also handles system control. Activation wakes the block from idle and starts the first fetch after a programmable number of cycles. Suspension parks the block in idle, either at once or when the current instruction finishes. Switch-out hands the block over to another engine and cancels any fetch that is counting down. Drain holds the block in a stopped state with no access in flight. The block acknowledges a drain at once when no access is outstanding. Otherwise it waits for the outstanding access to finish. Two counters report active cycles and retired instructions.

Top module: `seq_ctrl`

## Requirements
- R1: After reset, `state_o` reads 0 (idle), both memory requests and `drain_done_o` are low, and both counters read 0. The state codes are: idle 0, run 1, instruction-wait 2, instruction-retry 3, data-translate 4, data-wait 5, data-retry 6, switched-out 7, drained 8.
- R2: `activate_i` in idle moves the block to run and loads `act_delay_i`. `imem_req_o` first rises exactly `act_delay_i` cycles after run is entered. `activate_i` in any other state has no effect.
- R3: In run with the fetch due, `imem_req_o` is high. If `imem_gnt_i` is high, the block enters instruction-wait. Otherwise it enters instruction-retry, where the request stays high until granted.
- R4: When `ifetch_fault_i` is high in the fetch cycle, no instruction request is made and the block stays in run. It tries the next fetch in the following cycle, and the instruction does not count as retired.
- R5: An instruction reply with `is_mem_i` low completes the instruction. The block returns to run and requests the next fetch in the next cycle.
- R6: An instruction reply with `is_mem_i` high enters data-translate. When `dxlat_done_i` is high without a fault, `dmem_req_o` rises in that cycle. A grant then goes to data-wait, and no grant goes to data-retry, which holds the request. `dmem_rsp_i` in data-wait completes the instruction.
- R7: A translation fault on a prefetch (`is_pref_i` captured with the reply) is suppressed: the instruction retires and the block advances. A translation fault on any other access advances without retiring. Neither makes a data request.
- R8: `suspend_i` in run moves to idle at once. When it arrives during an access, the block finishes that access and then goes to idle without fetching.
- R9: `switch_out_i` takes effect only from run or idle. It moves to switched-out and cancels a pending fetch countdown. `takeover_i` in switched-out returns to run with the fetch due at once.
- R10: A drain request in idle, run or switched-out raises a one-cycle `drain_done_o` pulse on the next cycle. From run the block enters drained. During an access, the acknowledgement waits for completion, and then the block enters drained with the pulse. `resume_i` in drained returns to run.
- R11: `cycle_cnt_o` advances by one for each cycle spent outside idle, switched-out and drained, and holds otherwise.
- R12: `retire_cnt_o` advances by one for each completion without a fault, and for each suppressed prefetch fault. It never advances by more than one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| activate_i | input | 1 | Wake from idle |
| act_delay_i | input | DELAY_W | Cycles before the first fetch after wake |
| suspend_i | input | 1 | Park in idle |
| switch_out_i | input | 1 | Hand over execution |
| takeover_i | input | 1 | Resume after switch-out |
| drain_req_i | input | 1 | Drain request pulse |
| resume_i | input | 1 | Leave the drained state |
| drain_done_o | output | 1 | Drain acknowledge pulse |
| ifetch_fault_i | input | 1 | Fetch translation faulted |
| imem_req_o | output | 1 | Instruction port request |
| imem_gnt_i | input | 1 | Instruction port accepts the request |
| imem_rsp_i | input | 1 | Instruction reply |
| is_mem_i | input | 1 | Replied instruction accesses data memory |
| is_pref_i | input | 1 | Replied instruction is a prefetch |
| exec_fault_i | input | 1 | Execution or completion faulted |
| dxlat_done_i | input | 1 | Data translation finished |
| dxlat_fault_i | input | 1 | Data translation faulted |
| dmem_req_o | output | 1 | Data port request |
| dmem_gnt_i | input | 1 | Data port accepts the request |
| dmem_rsp_i | input | 1 | Data reply |
| state_o | output | 4 | Current state code |
| cycle_cnt_o | output | CNT_W | Active cycle count |
| retire_cnt_o | output | CNT_W | Retired instruction count |

## Verification
Both memory requests are combinational in the current state and inputs. The bench waits one nanosecond after driving inputs and then samples them in the same cycle. The state, the drain pulse and both counters are registered, so they change on the first rising edge after the stimulus. The bench drives on the falling edge and checks them on the following falling edge. A sweep over wake delays 0 to 5 and retry lengths 0 to 3 counts the request cycle by cycle. It predicts the active-cycle total as delay plus retries plus three. Directed sequences cover the fault, suspend, switch-out and drain orderings.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int ST_W = 4;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE    = 4'd0,
    ST_RUN     = 4'd1,
    ST_IWAIT   = 4'd2,
    ST_IRETRY  = 4'd3,
    ST_DXLAT   = 4'd4,
    ST_DWAIT   = 4'd5,
    ST_DRETRY  = 4'd6,
    ST_SWOUT   = 4'd7,
    ST_DRAINED = 4'd8
  } seq_state_e;
endpackage

// File: rtl/seq_fetch_timer.sv
// Countdown before a fetch is due; loaded on wake, forced to zero outside run.
module seq_fetch_timer #(
  parameter int DELAY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [DELAY_W-1:0] load_val_i,
  input  logic               run_i,
  output logic               due_o
);
  logic [DELAY_W-1:0] cnt_q, cnt_d;
  logic               cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)              cnt_d = load_val_i;
    else if (!run_i)         cnt_d = '0;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign due_o = (cnt_q == '0);
endmodule

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       activate_i,
  input  logic       suspend_i,
  input  logic       switch_out_i,
  input  logic       takeover_i,
  input  logic       drain_req_i,
  input  logic       resume_i,
  input  logic       ifetch_fault_i,
  input  logic       imem_gnt_i,
  input  logic       imem_rsp_i,
  input  logic       is_mem_i,
  input  logic       is_pref_i,
  input  logic       exec_fault_i,
  input  logic       dxlat_done_i,
  input  logic       dxlat_fault_i,
  input  logic       dmem_gnt_i,
  input  logic       dmem_rsp_i,
  input  logic       due_i,
  output seq_state_e state_o,
  output logic       load_o,
  output logic       imem_req_o,
  output logic       dmem_req_o,
  output logic       retire_o,
  output logic       active_o,
  output logic       drain_done_o
);
  seq_state_e st_q, st_d;
  logic spend_q, spend_d;
  logic dpend_q, dpend_d;
  logic pref_q;
  logic done_q, done_d;
  logic busy, complete, retire, fetch_go, pref_en;

  assign busy = (st_q inside {ST_IWAIT, ST_IRETRY, ST_DXLAT, ST_DWAIT, ST_DRETRY});

  // Fetch is attempted in run only when nothing of higher priority is asked.
  assign fetch_go = (st_q == ST_RUN) && due_i && !switch_out_i &&
                    !suspend_i && !drain_req_i;

  assign imem_req_o = (fetch_go && !ifetch_fault_i) || (st_q == ST_IRETRY);
  assign dmem_req_o = ((st_q == ST_DXLAT) && dxlat_done_i && !dxlat_fault_i) ||
                      (st_q == ST_DRETRY);
  assign load_o     = (st_q == ST_IDLE) && activate_i && !switch_out_i;
  assign active_o   = !(st_q inside {ST_IDLE, ST_SWOUT, ST_DRAINED});
  assign pref_en    = (st_q == ST_IWAIT) && imem_rsp_i && is_mem_i;

  always_comb begin
    st_d     = st_q;
    spend_d  = spend_q;
    dpend_d  = dpend_q;
    done_d   = 1'b0;
    complete = 1'b0;
    retire   = 1'b0;

    if (busy) begin
      if (drain_req_i) dpend_d = 1'b1;
      if (suspend_i)   spend_d = 1'b1;
    end

    case (st_q)
      ST_IDLE: begin
        done_d = drain_req_i;
        if (switch_out_i)    st_d = ST_SWOUT;
        else if (activate_i) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (switch_out_i) begin
          st_d   = ST_SWOUT;
          done_d = drain_req_i;
        end else if (suspend_i) begin
          st_d   = ST_IDLE;
          done_d = drain_req_i;
        end else if (drain_req_i) begin
          st_d   = ST_DRAINED;
          done_d = 1'b1;
        end else if (due_i && !ifetch_fault_i) begin
          st_d = imem_gnt_i ? ST_IWAIT : ST_IRETRY;
        end
      end
      ST_IRETRY: begin
        if (imem_gnt_i) st_d = ST_IWAIT;
      end
      ST_IWAIT: begin
        if (imem_rsp_i) begin
          if (is_mem_i) begin
            st_d = ST_DXLAT;
          end else begin
            complete = 1'b1;
            retire   = !exec_fault_i;
          end
        end
      end
      ST_DXLAT: begin
        if (dxlat_done_i) begin
          if (dxlat_fault_i) begin
            complete = 1'b1;
            retire   = pref_q;
          end else begin
            st_d = dmem_gnt_i ? ST_DWAIT : ST_DRETRY;
          end
        end
      end
      ST_DRETRY: begin
        if (dmem_gnt_i) st_d = ST_DWAIT;
      end
      ST_DWAIT: begin
        if (dmem_rsp_i) begin
          complete = 1'b1;
          retire   = !exec_fault_i;
        end
      end
      ST_SWOUT: begin
        done_d = drain_req_i;
        if (takeover_i) st_d = ST_RUN;
      end
      ST_DRAINED: begin
        if (resume_i) st_d = ST_RUN;
      end
      default: st_d = ST_IDLE;
    endcase

    if (complete) begin
      if (dpend_d) begin
        st_d   = ST_DRAINED;
        done_d = 1'b1;
      end else if (spend_d) begin
        st_d = ST_IDLE;
      end else begin
        st_d = ST_RUN;
      end
      dpend_d = 1'b0;
      spend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      spend_q <= 1'b0;
      dpend_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      spend_q <= spend_d;
      dpend_q <= dpend_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pref_q <= 1'b0;
    else if (pref_en) pref_q <= is_pref_i;
  end

  assign state_o      = st_q;
  assign retire_o     = retire;
  assign drain_done_o = done_q;
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int DELAY_W = 4,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               activate_i,
  input  logic [DELAY_W-1:0] act_delay_i,
  input  logic               suspend_i,
  input  logic               switch_out_i,
  input  logic               takeover_i,
  input  logic               drain_req_i,
  input  logic               resume_i,
  output logic               drain_done_o,
  input  logic               ifetch_fault_i,
  output logic               imem_req_o,
  input  logic               imem_gnt_i,
  input  logic               imem_rsp_i,
  input  logic               is_mem_i,
  input  logic               is_pref_i,
  input  logic               exec_fault_i,
  input  logic               dxlat_done_i,
  input  logic               dxlat_fault_i,
  output logic               dmem_req_o,
  input  logic               dmem_gnt_i,
  input  logic               dmem_rsp_i,
  output logic [ST_W-1:0]    state_o,
  output logic [CNT_W-1:0]   cycle_cnt_o,
  output logic [CNT_W-1:0]   retire_cnt_o
);
  localparam int NUM_CNT = 2;

  seq_state_e         st;
  logic               load, due, retire, active;
  logic [NUM_CNT-1:0] cnt_en;
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];

  seq_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .activate_i     (activate_i),
    .suspend_i      (suspend_i),
    .switch_out_i   (switch_out_i),
    .takeover_i     (takeover_i),
    .drain_req_i    (drain_req_i),
    .resume_i       (resume_i),
    .ifetch_fault_i (ifetch_fault_i),
    .imem_gnt_i     (imem_gnt_i),
    .imem_rsp_i     (imem_rsp_i),
    .is_mem_i       (is_mem_i),
    .is_pref_i      (is_pref_i),
    .exec_fault_i   (exec_fault_i),
    .dxlat_done_i   (dxlat_done_i),
    .dxlat_fault_i  (dxlat_fault_i),
    .dmem_gnt_i     (dmem_gnt_i),
    .dmem_rsp_i     (dmem_rsp_i),
    .due_i          (due),
    .state_o        (st),
    .load_o         (load),
    .imem_req_o     (imem_req_o),
    .dmem_req_o     (dmem_req_o),
    .retire_o       (retire),
    .active_o       (active),
    .drain_done_o   (drain_done_o)
  );

  seq_fetch_timer #(.DELAY_W(DELAY_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (act_delay_i),
    .run_i      (st == ST_RUN),
    .due_o      (due)
  );

  assign cnt_en[0] = active;
  assign cnt_en[1] = retire;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    seq_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (cnt_en[g]),
      .cnt_o (cnt_val[g])
    );
  end

  assign cycle_cnt_o  = cnt_val[0];
  assign retire_cnt_o = cnt_val[1];
  assign state_o      = st;
endmodule

// File: rtl/seq_ctrl_chk.sv
module seq_ctrl_chk
  import seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             activate_i,
  input logic             imem_gnt_i,
  input logic             imem_req_o,
  input logic             dmem_req_o,
  input logic             drain_done_o,
  input logic [ST_W-1:0]  state_o,
  input logic [CNT_W-1:0] cycle_cnt_o,
  input logic [CNT_W-1:0] retire_cnt_o
);
  AST_IREQ_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req_o |-> (state_o == ST_RUN || state_o == ST_IRETRY)); // R3

  AST_IRETRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_IRETRY && !imem_gnt_i) |=> (state_o == ST_IRETRY)); // R3

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(imem_req_o && dmem_req_o)); // R6

  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_IDLE && !activate_i) |=> (state_o != ST_RUN)); // R2

  AST_SWOUT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_SWOUT && $past(state_o) != ST_SWOUT) |->
      ($past(state_o) == ST_RUN || $past(state_o) == ST_IDLE)); // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done_o |-> (state_o == ST_IDLE || state_o == ST_SWOUT ||
                      state_o == ST_DRAINED)); // R10

  AST_CYC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_IDLE || state_o == ST_SWOUT || state_o == ST_DRAINED)
      |=> $stable(cycle_cnt_o)); // R11

  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_cnt_o == $past(retire_cnt_o)) ||
    (retire_cnt_o == $past(retire_cnt_o) + 1'b1)); // R12
endmodule

bind seq_ctrl seq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .activate_i   (activate_i),
  .imem_gnt_i   (imem_gnt_i),
  .imem_req_o   (imem_req_o),
  .dmem_req_o   (dmem_req_o),
  .drain_done_o (drain_done_o),
  .state_o      (state_o),
  .cycle_cnt_o  (cycle_cnt_o),
  .retire_cnt_o (retire_cnt_o)
);

// File: tb/seq_ctrl_tb.sv
`timescale 1ns/1ps
module seq_ctrl_tb;
  localparam int DW = 4;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic activate_i, suspend_i, switch_out_i, takeover_i, drain_req_i, resume_i;
  logic [DW-1:0] act_delay_i;
  logic ifetch_fault_i, imem_gnt_i, imem_rsp_i, is_mem_i, is_pref_i, exec_fault_i;
  logic dxlat_done_i, dxlat_fault_i, dmem_gnt_i, dmem_rsp_i;
  logic drain_done_o, imem_req_o, dmem_req_o;
  logic [3:0] state_o;
  logic [CW-1:0] cycle_cnt_o, retire_cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  int exp_ret = 0;

  always #2.5 clk = ~clk;

  seq_ctrl #(.DELAY_W(DW), .CNT_W(CW)) u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr();
    activate_i = 0; suspend_i = 0; switch_out_i = 0; takeover_i = 0;
    drain_req_i = 0; resume_i = 0; act_delay_i = '0; ifetch_fault_i = 0;
    imem_gnt_i = 0; imem_rsp_i = 0; is_mem_i = 0; is_pref_i = 0;
    exec_fault_i = 0; dxlat_done_i = 0; dxlat_fault_i = 0;
    dmem_gnt_i = 0; dmem_rsp_i = 0;
  endtask

  task automatic go_run();
    activate_i = 1; act_delay_i = '0; tick(); clr();
  endtask

  task automatic fetch_ok();
    imem_gnt_i = 1; tick(); clr();
  endtask

  task automatic to_dwait();
    fetch_ok();
    imem_rsp_i = 1; is_mem_i = 1; tick(); clr();
    dxlat_done_i = 1; dmem_gnt_i = 1; tick(); clr();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c0;
    clr();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 state", state_o, 0);
    chk("R1 ireq", imem_req_o, 0);
    chk("R1 dreq", dmem_req_o, 0);
    chk("R1 done", drain_done_o, 0);
    chk("R1 cyc", cycle_cnt_o, 0);
    chk("R1 ret", retire_cnt_o, 0);

    // Sweep wake delay and retry length
    for (int d = 0; d <= 5; d++) begin
      for (int r = 0; r <= 3; r++) begin
        c0 = cycle_cnt_o;
        activate_i = 1; act_delay_i = DW'(d); tick(); clr();
        chk("R2 run", state_o, 1);
        chk("R2 req0", imem_req_o, (d == 0) ? 1 : 0);
        for (int k = 1; k <= d; k++) begin
          tick();
          chk("R2 reqk", imem_req_o, (k == d) ? 1 : 0);
        end
        for (int j = 0; j < r; j++) begin
          tick();
          chk("R3 retry", state_o, 3);
          chk("R3 hold", imem_req_o, 1);
        end
        fetch_ok();
        chk("R3 iwait", state_o, 2);
        chk("R3 noreq", imem_req_o, 0);
        imem_rsp_i = 1; tick(); clr();
        exp_ret++;
        chk("R5 run", state_o, 1);
        chk("R5 next", imem_req_o, 1);
        chk("R12 ret", retire_cnt_o, exp_ret);
        suspend_i = 1; tick(); clr();
        chk("R8 idle", state_o, 0);
        chk("R11 cyc", cycle_cnt_o, c0 + d + r + 3);
      end
    end

    // R4 fetch fault
    go_run();
    ifetch_fault_i = 1; #1;
    chk("R4 noreq", imem_req_o, 0);
    tick(); clr();
    chk("R4 run", state_o, 1);
    chk("R4 ret", retire_cnt_o, exp_ret);
    #1 chk("R4 refetch", imem_req_o, 1);

    // R2 activate ignored in run (timer not reloaded)
    activate_i = 1; act_delay_i = 4'd5; ifetch_fault_i = 1; tick(); clr();
    chk("R2 ign state", state_o, 1);
    #1 chk("R2 ign req", imem_req_o, 1);

    // R5 exec fault: no retire
    fetch_ok();
    imem_rsp_i = 1; exec_fault_i = 1; tick(); clr();
    chk("R5 fault run", state_o, 1);
    chk("R5 fault ret", retire_cnt_o, exp_ret);

    // R6 data path with retry
    fetch_ok();
    imem_rsp_i = 1; is_mem_i = 1; tick(); clr();
    chk("R6 dxlat", state_o, 4);
    chk("R6 dreq0", dmem_req_o, 0);
    dxlat_done_i = 1; #1;
    chk("R6 dreq", dmem_req_o, 1);
    tick(); clr();
    chk("R6 dretry", state_o, 6);
    chk("R6 dhold", dmem_req_o, 1);
    tick();
    chk("R6 dretry2", state_o, 6);
    dmem_gnt_i = 1; tick(); clr();
    chk("R6 dwait", state_o, 5);
    chk("R6 dnoreq", dmem_req_o, 0);
    dmem_rsp_i = 1; tick(); clr();
    exp_ret++;
    chk("R6 done", state_o, 1);
    chk("R6 ret", retire_cnt_o, exp_ret);

    // R6 direct grant
    to_dwait();
    chk("R6 direct", state_o, 5);
    dmem_rsp_i = 1; tick(); clr();
    exp_ret++;
    chk("R6 ret2", retire_cnt_o, exp_ret);

    // R7 prefetch fault suppressed
    fetch_ok();
    imem_rsp_i = 1; is_mem_i = 1; is_pref_i = 1; tick(); clr();
    dxlat_done_i = 1; dxlat_fault_i = 1; #1;
    chk("R7 pf noreq", dmem_req_o, 0);
    tick(); clr();
    exp_ret++;
    chk("R7 pf run", state_o, 1);
    chk("R7 pf ret", retire_cnt_o, exp_ret);

    // R7 ordinary translation fault
    fetch_ok();
    imem_rsp_i = 1; is_mem_i = 1; tick(); clr();
    dxlat_done_i = 1; dxlat_fault_i = 1; tick(); clr();
    chk("R7 flt run", state_o, 1);
    chk("R7 flt ret", retire_cnt_o, exp_ret);

    // R8 suspend during access
    fetch_ok();
    suspend_i = 1; tick(); clr();
    chk("R8 still", state_o, 2);
    imem_rsp_i = 1; tick(); clr();
    exp_ret++;
    chk("R8 idle", state_o, 0);
    chk("R8 nofetch", imem_req_o, 0);
    chk("R8 ret", retire_cnt_o, exp_ret);

    // R9 switch-out cancels pending countdown
    activate_i = 1; act_delay_i = 4'd6; tick(); clr();
    switch_out_i = 1; tick(); clr();
    chk("R9 swout", state_o, 7);
    activate_i = 1; tick(); clr();
    chk("R9 act ign", state_o, 7);
    c0 = cycle_cnt_o;
    tick(); tick();
    chk("R11 frozen", cycle_cnt_o, c0);
    takeover_i = 1; tick(); clr();
    chk("R9 take", state_o, 1);
    chk("R9 cancel", imem_req_o, 1);
    fetch_ok();
    switch_out_i = 1; tick(); clr();
    chk("R9 busy ign", state_o, 2);
    imem_rsp_i = 1; tick(); clr();
    exp_ret++;
    chk("R9 back", state_o, 1);
    suspend_i = 1; tick(); clr();
    switch_out_i = 1; tick(); clr();
    chk("R9 from idle", state_o, 7);

    // R10 drain in switched-out
    drain_req_i = 1; tick(); clr();
    chk("R10 sw done", drain_done_o, 1);
    chk("R10 sw state", state_o, 7);
    takeover_i = 1; tick(); clr();
    chk("R10 sw pulse", drain_done_o, 0);

    // R10 drain in run
    drain_req_i = 1; tick(); clr();
    chk("R10 run drained", state_o, 8);
    chk("R10 run done", drain_done_o, 1);
    tick();
    chk("R10 pulse end", drain_done_o, 0);
    chk("R10 hold", state_o, 8);
    resume_i = 1; tick(); clr();
    chk("R10 resume", state_o, 1);
    chk("R10 refetch", imem_req_o, 1);

    // R10 drain in idle
    suspend_i = 1; tick(); clr();
    drain_req_i = 1; tick(); clr();
    chk("R10 idle state", state_o, 0);
    chk("R10 idle done", drain_done_o, 1);
    go_run();

    // R10 deferred drain
    to_dwait();
    drain_req_i = 1; tick(); clr();
    chk("R10 defer state", state_o, 5);
    chk("R10 defer done", drain_done_o, 0);
    dmem_rsp_i = 1; tick(); clr();
    exp_ret++;
    chk("R10 late drained", state_o, 8);
    chk("R10 late done", drain_done_o, 1);
    chk("R12 final ret", retire_cnt_o, exp_ret);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule